// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard unit for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It is purely combinational. It looks at the register fields and the operation class held in the four inter-stage registers. From these it decides three things:

- whether the decode-stage instruction must wait one cycle behind a load;
- which source feeds each of the two execute-stage operands;
- which source supplies the data of a store in the memory stage.

The surrounding pipeline uses the outputs directly. When a stall is raised, the program counter and the fetch/decode register keep their contents, and a bubble with all control cleared enters the decode/execute register. The forwarding selects drive the operand multiplexers in execute and the store-data multiplexer in memory. The register file is assumed to write in the first half of the cycle and read in the second half. A reader three stages behind a writer therefore sees the new value without help.

Top module: `hazard_ctrl`

## Requirements
- R1: `fwd_a_sel_o` selects 0 (memory-stage ALU result) when the execute-stage rs1 matches the memory-stage destination. Failing that, it selects 1 (writeback value) when rs1 matches the writeback-stage destination. Otherwise it selects 2 (register file). The value 3 never appears.
- R2: `fwd_b_sel_o` follows the same priority and encoding as R1, independently, using the execute-stage rs2.
- R3: A destination counts as a match only when its write-enable is 1 and it is not register 0. Register 0 is never forwarded and never stalls.
- R4: `stall_o` is 1 when the execute stage holds a writing load (op code 1) whose destination equals the decode-stage rs1.
- R5: `stall_o` is also 1 when that load's destination equals the decode-stage rs2 and the decode-stage op is not a store (op code 2). A store's rs2 alone never stalls.
- R6: While `stall_o` is 1, `pc_we_o` and `fd_we_o` are 0 and `dx_nop_o` is 1. While it is 0, the first two are 1 and `dx_nop_o` is 0.
- R7: Only an execute-stage load can stall. Decode-stage sources that match memory- or writeback-stage destinations never stall, because those writers are forwarded or written first.
- R8: `st_data_sel_o` is 1 (writeback value) when the memory-stage op is a store whose rs2 matches the writeback-stage destination. Otherwise it is 0 (memory-stage data field).
- R9: In a running pipeline, a load followed at once by a dependent instruction stalls for exactly one cycle. After the bubble, the dependent operands select 1 (writeback).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fd_rs1_i | input | REG_W | Decode-stage source 1 |
| fd_rs2_i | input | REG_W | Decode-stage source 2 |
| fd_op_i | input | 2 | Decode-stage op class (0 other, 1 load, 2 store) |
| dx_rs1_i | input | REG_W | Execute-stage source 1 |
| dx_rs2_i | input | REG_W | Execute-stage source 2 |
| dx_rd_i | input | REG_W | Execute-stage destination |
| dx_wen_i | input | 1 | Execute-stage register write |
| dx_op_i | input | 2 | Execute-stage op class |
| xm_rs2_i | input | REG_W | Memory-stage source 2 (store data register) |
| xm_rd_i | input | REG_W | Memory-stage destination |
| xm_wen_i | input | 1 | Memory-stage register write |
| xm_op_i | input | 2 | Memory-stage op class |
| mw_rd_i | input | REG_W | Writeback-stage destination |
| mw_wen_i | input | 1 | Writeback-stage register write |
| stall_o | output | 1 | Load-use stall request |
| pc_we_o | output | 1 | Program counter write enable |
| fd_we_o | output | 1 | Fetch/decode register write enable |
| dx_nop_o | output | 1 | Load a bubble into decode/execute |
| fwd_a_sel_o | output | 2 | Operand A source select |
| fwd_b_sel_o | output | 2 | Operand B source select |
| st_data_sel_o | output | 1 | Store-data source select |

## Verification
The assertions check, on every input combination, the properties that follow from the current inputs alone:

- a memory-stage or writeback-stage select is only produced when a real, non-zero writing destination matches;
- register 0 never forwards;
- a stall only appears behind a load;
- the three pipeline control outputs stay mutually consistent;
- the store-data select only fires for a store.

Only the bench's sequences can show behaviour across cycles. Running a small program through a modelled pipeline, the bench shows that a load-use stall lasts exactly one cycle and that the bubble resolves the dependence through the writeback forward. It also shows that a store then receives its data from the writeback stage.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int OP_W  = 2;
  localparam int SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_OTHER = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } op_e;

  typedef enum logic [SEL_W-1:0] {
    FWD_MEM = 2'd0,
    FWD_WB  = 2'd1,
    FWD_RF  = 2'd2
  } fwd_e;
endpackage

// File: rtl/hazard_match.sv
module hazard_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             wen_i,
  output logic             hit_o
);
  // register 0 is hard-wired, never a producer
  assign hit_o = wen_i && (rd_i != '0) && (src_i == rd_i);
endmodule

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] xm_rd_i,
  input  logic             xm_wen_i,
  input  logic [REG_W-1:0] mw_rd_i,
  input  logic             mw_wen_i,
  output logic [SEL_W-1:0] sel_o
);
  logic hit_xm, hit_mw;

  hazard_match #(.REG_W(REG_W)) u_m_xm (
    .src_i(src_i), .rd_i(xm_rd_i), .wen_i(xm_wen_i), .hit_o(hit_xm)
  );
  hazard_match #(.REG_W(REG_W)) u_m_mw (
    .src_i(src_i), .rd_i(mw_rd_i), .wen_i(mw_wen_i), .hit_o(hit_mw)
  );

  // youngest producer wins
  always_comb begin
    if (hit_xm)      sel_o = FWD_MEM;
    else if (hit_mw) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hazard_load_stall.sv
module hazard_load_stall
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] fd_rs1_i,
  input  logic [REG_W-1:0] fd_rs2_i,
  input  logic [OP_W-1:0]  fd_op_i,
  input  logic [REG_W-1:0] dx_rd_i,
  input  logic             dx_wen_i,
  input  logic [OP_W-1:0]  dx_op_i,
  output logic             stall_o
);
  logic hit_rs1, hit_rs2, dx_load, fd_store;

  hazard_match #(.REG_W(REG_W)) u_m_rs1 (
    .src_i(fd_rs1_i), .rd_i(dx_rd_i), .wen_i(dx_wen_i), .hit_o(hit_rs1)
  );
  hazard_match #(.REG_W(REG_W)) u_m_rs2 (
    .src_i(fd_rs2_i), .rd_i(dx_rd_i), .wen_i(dx_wen_i), .hit_o(hit_rs2)
  );

  assign dx_load  = (dx_op_i == OP_LOAD);
  assign fd_store = (fd_op_i == OP_STORE);
  // store data reaches memory stage late enough for a writeback forward
  assign stall_o  = dx_load && (hit_rs1 || (hit_rs2 && !fd_store));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] fd_rs1_i,
  input  logic [REG_W-1:0] fd_rs2_i,
  input  logic [1:0]       fd_op_i,
  input  logic [REG_W-1:0] dx_rs1_i,
  input  logic [REG_W-1:0] dx_rs2_i,
  input  logic [REG_W-1:0] dx_rd_i,
  input  logic             dx_wen_i,
  input  logic [1:0]       dx_op_i,
  input  logic [REG_W-1:0] xm_rs2_i,
  input  logic [REG_W-1:0] xm_rd_i,
  input  logic             xm_wen_i,
  input  logic [1:0]       xm_op_i,
  input  logic [REG_W-1:0] mw_rd_i,
  input  logic             mw_wen_i,
  output logic             stall_o,
  output logic             pc_we_o,
  output logic             fd_we_o,
  output logic             dx_nop_o,
  output logic [1:0]       fwd_a_sel_o,
  output logic [1:0]       fwd_b_sel_o,
  output logic             st_data_sel_o
);
  localparam int N_OPND = 2;

  logic [REG_W-1:0] opnd_src [N_OPND];
  logic [SEL_W-1:0] opnd_sel [N_OPND];
  logic             stall;
  logic             st_hit;

  assign opnd_src[0] = dx_rs1_i;
  assign opnd_src[1] = dx_rs2_i;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
    hazard_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src_i   (opnd_src[gi]),
      .xm_rd_i (xm_rd_i),
      .xm_wen_i(xm_wen_i),
      .mw_rd_i (mw_rd_i),
      .mw_wen_i(mw_wen_i),
      .sel_o   (opnd_sel[gi])
    );
  end

  assign fwd_a_sel_o = opnd_sel[0];
  assign fwd_b_sel_o = opnd_sel[1];

  hazard_load_stall #(.REG_W(REG_W)) u_stall (
    .fd_rs1_i(fd_rs1_i),
    .fd_rs2_i(fd_rs2_i),
    .fd_op_i (fd_op_i),
    .dx_rd_i (dx_rd_i),
    .dx_wen_i(dx_wen_i),
    .dx_op_i (dx_op_i),
    .stall_o (stall)
  );

  assign stall_o  = stall;
  assign pc_we_o  = !stall;
  assign fd_we_o  = !stall;
  assign dx_nop_o = stall;

  // writeback-to-memory forward for store data only
  hazard_match #(.REG_W(REG_W)) u_st_match (
    .src_i(xm_rs2_i), .rd_i(mw_rd_i), .wen_i(mw_wen_i), .hit_o(st_hit)
  );
  assign st_data_sel_o = (xm_op_i == OP_STORE) && st_hit;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] fd_rs1_i,
  input logic [REG_W-1:0] fd_rs2_i,
  input logic [1:0]       fd_op_i,
  input logic [REG_W-1:0] dx_rs1_i,
  input logic [REG_W-1:0] dx_rs2_i,
  input logic [REG_W-1:0] dx_rd_i,
  input logic             dx_wen_i,
  input logic [1:0]       dx_op_i,
  input logic [REG_W-1:0] xm_rs2_i,
  input logic [REG_W-1:0] xm_rd_i,
  input logic             xm_wen_i,
  input logic [1:0]       xm_op_i,
  input logic [REG_W-1:0] mw_rd_i,
  input logic             mw_wen_i,
  input logic             stall_o,
  input logic             pc_we_o,
  input logic             fd_we_o,
  input logic             dx_nop_o,
  input logic [1:0]       fwd_a_sel_o,
  input logic [1:0]       fwd_b_sel_o,
  input logic             st_data_sel_o
);
  logic known;
  assign known = !$isunknown({fd_rs1_i, fd_rs2_i, fd_op_i, dx_rs1_i, dx_rs2_i,
                               dx_rd_i, dx_wen_i, dx_op_i, xm_rs2_i, xm_rd_i,
                               xm_wen_i, xm_op_i, mw_rd_i, mw_wen_i});

  always_comb begin
    if (known) begin
      AST_A_MEM_SRC: assert (fwd_a_sel_o != 2'd0 ||
        (xm_wen_i && xm_rd_i != '0 && xm_rd_i == dx_rs1_i));  // R1
      AST_A_WB_SRC: assert (fwd_a_sel_o != 2'd1 ||
        (mw_wen_i && mw_rd_i != '0 && mw_rd_i == dx_rs1_i &&
         !(xm_wen_i && xm_rd_i == dx_rs1_i)));                // R1
      AST_A_LEGAL: assert (fwd_a_sel_o != 2'd3);              // R1
      AST_B_MEM_SRC: assert (fwd_b_sel_o != 2'd0 ||
        (xm_wen_i && xm_rd_i != '0 && xm_rd_i == dx_rs2_i));  // R2
      AST_B_LEGAL: assert (fwd_b_sel_o != 2'd3);              // R2
      AST_ZERO_NO_FWD: assert (dx_rs1_i != '0 || fwd_a_sel_o == 2'd2);  // R3
      AST_STALL_LOAD_ONLY: assert (!stall_o || (dx_op_i == 2'd1 && dx_wen_i));  // R7
      AST_STORE_RS2_EXEMPT: assert (!(fd_op_i == 2'd2 && fd_rs1_i != dx_rd_i) ||
        !stall_o);                                            // R5
      AST_STALL_CTRL: assert (pc_we_o == fd_we_o && pc_we_o != dx_nop_o &&
        dx_nop_o == stall_o);                                 // R6
      AST_ST_SEL_STORE: assert (!st_data_sel_o ||
        (xm_op_i == 2'd2 && mw_wen_i && mw_rd_i == xm_rs2_i)); // R8
    end
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
  localparam int REG_W  = 2;
  localparam int NREG   = 1 << REG_W;
  localparam int CLK_PS = 10;
  localparam int WDOG   = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PS/2) clk = ~clk;

  logic [REG_W-1:0] fd_rs1, fd_rs2, dx_rs1, dx_rs2, dx_rd, xm_rs2, xm_rd, mw_rd;
  logic [1:0] fd_op, dx_op, xm_op;
  logic dx_wen, xm_wen, mw_wen;
  logic stall, pc_we, fd_we, dx_nop, st_sel;
  logic [1:0] sel_a, sel_b;

  hazard_ctrl #(.REG_W(REG_W)) uut (
    .fd_rs1_i(fd_rs1), .fd_rs2_i(fd_rs2), .fd_op_i(fd_op),
    .dx_rs1_i(dx_rs1), .dx_rs2_i(dx_rs2), .dx_rd_i(dx_rd),
    .dx_wen_i(dx_wen), .dx_op_i(dx_op),
    .xm_rs2_i(xm_rs2), .xm_rd_i(xm_rd), .xm_wen_i(xm_wen), .xm_op_i(xm_op),
    .mw_rd_i(mw_rd), .mw_wen_i(mw_wen),
    .stall_o(stall), .pc_we_o(pc_we), .fd_we_o(fd_we), .dx_nop_o(dx_nop),
    .fwd_a_sel_o(sel_a), .fwd_b_sel_o(sel_b), .st_data_sel_o(st_sel)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(int src, int xrd, int xw, int mrd, int mw);
    if (xw != 0 && xrd != 0 && xrd == src) return 0;
    if (mw != 0 && mrd != 0 && mrd == src) return 1;
    return 2;
  endfunction

  function automatic int exp_stall(int r1, int r2, int fop, int rd, int w, int dop);
    if (dop != 1 || w == 0 || rd == 0) return 0;
    if (r1 == rd) return 1;
    if (r2 == rd && fop != 2) return 1;
    return 0;
  endfunction

  task automatic clear_all();
    fd_rs1 = '0; fd_rs2 = '0; fd_op = 2'd0;
    dx_rs1 = '0; dx_rs2 = '0; dx_rd = '0; dx_wen = 1'b0; dx_op = 2'd0;
    xm_rs2 = '0; xm_rd = '0; xm_wen = 1'b0; xm_op = 2'd0;
    mw_rd = '0; mw_wen = 1'b0;
  endtask

  // pipeline model: rs1, rs2, rd, wen, op
  typedef struct packed {
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             wen;
    logic [1:0]       op;
  } insn_t;

  localparam insn_t NOP = '{rs1: '0, rs2: '0, rd: '0, wen: 1'b0, op: 2'd0};

  insn_t prog [4];
  insn_t p_fd, p_dx, p_xm, p_mw;
  int    pc;

  task automatic drive_pipe();
    fd_rs1 = p_fd.rs1; fd_rs2 = p_fd.rs2; fd_op = p_fd.op;
    dx_rs1 = p_dx.rs1; dx_rs2 = p_dx.rs2; dx_rd = p_dx.rd;
    dx_wen = p_dx.wen; dx_op = p_dx.op;
    xm_rs2 = p_xm.rs2; xm_rd = p_xm.rd; xm_wen = p_xm.wen; xm_op = p_xm.op;
    mw_rd = p_mw.rd; mw_wen = p_mw.wen;
  endtask

  initial begin
    #(CLK_PS*WDOG);
    if (!done) begin
      check(1'b0, "WATCHDOG", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    #(CLK_PS);
    rst_ni = 1'b1;
    #1;
    // idle state
    check(stall == 1'b0 && pc_we && fd_we && !dx_nop, "R6 idle", int'(stall), 0);
    check(sel_a == 2'd2 && sel_b == 2'd2, "R3 idle sel", int'(sel_a), 2);
    check(st_sel == 1'b0, "R8 idle", int'(st_sel), 0);

    // forwarding sweep, both operands, all destination/enable combinations
    for (int s = 0; s < NREG; s++)
      for (int xr = 0; xr < NREG; xr++)
        for (int xw = 0; xw < 2; xw++)
          for (int mr = 0; mr < NREG; mr++)
            for (int mw = 0; mw < 2; mw++) begin
              clear_all();
              dx_rs1 = s[REG_W-1:0];
              dx_rs2 = REG_W'((s + 1) % NREG);
              xm_rd = xr[REG_W-1:0]; xm_wen = xw[0];
              mw_rd = mr[REG_W-1:0]; mw_wen = mw[0];
              #1;
              check(int'(sel_a) == exp_sel(s, xr, xw, mr, mw), "R1 sel_a",
                    int'(sel_a), exp_sel(s, xr, xw, mr, mw));
              check(int'(sel_b) == exp_sel((s + 1) % NREG, xr, xw, mr, mw), "R2 sel_b",
                    int'(sel_b), exp_sel((s + 1) % NREG, xr, xw, mr, mw));
              check(stall == 1'b0, "R7 no stall from later stages", int'(stall), 0);
            end

    // stall sweep; also places matching later-stage destinations (R7)
    for (int r1 = 0; r1 < NREG; r1++)
      for (int r2 = 0; r2 < NREG; r2++)
        for (int fo = 0; fo < 3; fo++)
          for (int rd = 0; rd < NREG; rd++)
            for (int w = 0; w < 2; w++)
              for (int dop = 0; dop < 3; dop++) begin
                clear_all();
                fd_rs1 = r1[REG_W-1:0]; fd_rs2 = r2[REG_W-1:0]; fd_op = fo[1:0];
                dx_rd = rd[REG_W-1:0]; dx_wen = w[0]; dx_op = dop[1:0];
                xm_rd = r1[REG_W-1:0]; xm_wen = 1'b1; xm_op = 2'd1;
                mw_rd = r2[REG_W-1:0]; mw_wen = 1'b1;
                #1;
                check(int'(stall) == exp_stall(r1, r2, fo, rd, w, dop),
                      (fo == 2) ? "R5 store stall" : "R4 load stall",
                      int'(stall), exp_stall(r1, r2, fo, rd, w, dop));
                check(pc_we == !stall && fd_we == !stall && dx_nop == stall,
                      "R6 stall controls", int'(pc_we), int'(!stall));
              end

    // store-data select sweep
    for (int xo = 0; xo < 4; xo++)
      for (int x2 = 0; x2 < NREG; x2++)
        for (int mr = 0; mr < NREG; mr++)
          for (int mw = 0; mw < 2; mw++) begin
            int e;
            clear_all();
            xm_op = xo[1:0]; xm_rs2 = x2[REG_W-1:0];
            mw_rd = mr[REG_W-1:0]; mw_wen = mw[0];
            #1;
            e = (xo == 2 && mw != 0 && mr != 0 && mr == x2) ? 1 : 0;
            check(int'(st_sel) == e, "R8 st_sel", int'(st_sel), e);
          end

    // pipeline run: load r3; add r2<-r3,r3; store r2 -> [r1]; nop
    prog[0] = '{rs1: 2'd1, rs2: 2'd0, rd: 2'd3, wen: 1'b1, op: 2'd1};
    prog[1] = '{rs1: 2'd3, rs2: 2'd3, rd: 2'd2, wen: 1'b1, op: 2'd0};
    prog[2] = '{rs1: 2'd1, rs2: 2'd2, rd: 2'd0, wen: 1'b0, op: 2'd2};
    prog[3] = NOP;
    p_fd = NOP; p_dx = NOP; p_xm = NOP; p_mw = NOP; pc = 0;
    begin
      int stall_cycles = 0;
      drive_pipe();
      for (int cyc = 1; cyc <= 8; cyc++) begin
        @(negedge clk);
        if (stall) stall_cycles++;
        @(posedge clk);
        p_mw = p_xm;
        p_xm = p_dx;
        if (stall) p_dx = NOP;
        else begin
          p_dx = p_fd;
          p_fd = (pc < 4) ? prog[pc] : NOP;
          pc++;
        end
        drive_pipe();
        #1;
        case (cyc)
          2: check(stall == 1'b1, "R9 load-use stall raised", int'(stall), 1);
          3: check(stall == 1'b0, "R9 stall lasts one cycle", int'(stall), 0);
          4: check(sel_a == 2'd1 && sel_b == 2'd1, "R9 writeback forward after bubble",
                   int'(sel_a), 1);
          5: check(sel_b == 2'd0 && sel_a == 2'd2, "R2 store data from memory stage",
                   int'(sel_b), 0);
          6: check(st_sel == 1'b1, "R8 store data from writeback", int'(st_sel), 1);
          default: ;
        endcase
      end
      check(stall_cycles == 1, "R9 total stall cycles", stall_cycles, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule